// File: doc/BRIEF.md
# Speaker Load Diagnostic Sequencer

This block runs the output load tests for a multi-channel bridge amplifier. A host writes a control word with the start bit set. If at least one channel output is in the high-impedance state, the sequencer captures which channels are high-impedance and runs the test. The run has a synchronization interval, then a series of test windows, then a settling interval. During each window it raises one select strobe to the analog test circuits. At the last cycle of the window it latches each channel's comparator bit into that channel's result bit for the window.

When every channel is high-impedance, the sequencer runs the full test. The full test covers ground-short, supply-short, open-load and shorted-load, with all channels tested in lockstep. When only some channels are high-impedance, it runs only the two short windows, and the channels that were driving read back as clean. A start request with no channel in high-impedance is refused, and the refusal is flagged. A control write made while a run is active has no effect. Interval lengths are parameters in clock cycles, so that they can be scaled to the real durations: roughly 200 ms for synchronization, 50 ms per window and 150 ms for settling.

Top module: `load_diag_seq`

## Requirements
- R1: During and after reset the block is idle: `busy_o`, `done_o`, `reject_o`, `full_o`, every strobe and every result bit are 0.
- R2: A start request (control write with bit 0 set) while idle and with no channel in high-impedance is refused: `reject_o` pulses high for one cycle, `busy_o` stays low, and the results and `done_o` keep their values.
- R3: With all channels high-impedance at the start, the run raises the strobes in the order bit 0 (short to ground), bit 1 (short to supply), bit 2 (open load), bit 3 (shorted load). `busy_o` is high for SYNC_CYC + 4*PHASE_CYC + SETTLE_CYC cycles, and `full_o` reads 1.
- R4: With some but not all channels high-impedance, only strobe bits 0 and 1 are raised. `busy_o` is high for SYNC_CYC + 2*PHASE_CYC + SETTLE_CYC cycles, and `full_o` reads 0.
- R5: At most one strobe is high at any time. All strobes are low while idle and during the synchronization and settling intervals. The first strobe rises SYNC_CYC busy cycles after the start, and each strobe stays high for exactly PHASE_CYC cycles.
- R6: The comparator input of channel c is sampled only at the last cycle of the window for phase p. It is stored in `result_o[4*c+p]`, and the results do not change outside those sampling edges.
- R7: A channel that was not high-impedance when the run started reads 0 in all of its result bits, whatever its comparator shows.
- R8: An accepted start clears all result bits and `done_o`. `done_o` rises when the settling interval ends and stays high until the next accepted start.
- R9: A control write while busy, or a control write with bit 0 clear, has no effect. It does not restart the run, refuse, change the timing, or clear results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | CTL_W | Control write data; bit 0 requests a start |
| hiz_i | input | NCH | Per-channel high-impedance status |
| cmp_i | input | NCH | Per-channel comparator result for the active window |
| phase_sel_o | output | 4 | One-hot test window strobes to the analog test circuits |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last accepted sequence has completed |
| reject_o | output | 1 | One-cycle pulse on a refused start |
| full_o | output | 1 | Current or last run is the full four-window test |
| result_o | output | NCH*4 | Latched results, bit 4*c+p for channel c and window p |

## Verification
The bench drives the comparator from the strobe it observes. Each window gets its own channel pattern, and the lines are forced high outside the windows, so any sample taken at the wrong time or stored in the wrong position shows up as a wrong bit. The patterns include all-zero, all-one, a single diagonal and mixed nibbles. These separate a swap of windows or channels from a stuck bit, and runs with all, several, one and no channels in high-impedance separate the full test, the reduced test, masking and refusal. Directed cases cover a write during a run, a write without the start bit, and the timing of each interval, counted in cycles at the ports.

// File: rtl/ldiag_pkg.sv
package ldiag_pkg;

  localparam int NPH = 4;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SYNC   = 3'd1,
    ST_GND    = 3'd2,
    ST_SUP    = 3'd3,
    ST_OPEN   = 3'd4,
    ST_SHRT   = 3'd5,
    ST_SETTLE = 3'd6
  } ldiag_state_e;

  function automatic logic is_test(ldiag_state_e s);
    return (s == ST_GND) || (s == ST_SUP) || (s == ST_OPEN) || (s == ST_SHRT);
  endfunction

  // window index; this also sets the result bit position within a channel
  function automatic logic [1:0] phase_idx(ldiag_state_e s);
    case (s)
      ST_SUP:  return 2'd1;
      ST_OPEN: return 2'd2;
      ST_SHRT: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [NPH-1:0] phase_onehot(ldiag_state_e s);
    if (is_test(s)) return NPH'(1) << phase_idx(s);
    return '0;
  endfunction

  function automatic ldiag_state_e next_state(ldiag_state_e s, logic full);
    case (s)
      ST_SYNC: return ST_GND;
      ST_GND:  return ST_SUP;
      ST_SUP:  return full ? ST_OPEN : ST_SETTLE;
      ST_OPEN: return ST_SHRT;
      ST_SHRT: return ST_SETTLE;
      default: return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/ldiag_timer.sv
module ldiag_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [CW-1:0] len,
  output logic          seg_end
);
  logic [CW-1:0] cnt;

  assign seg_end = run && (cnt == len - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || !run)   cnt <= '0;
    else if (seg_end)           cnt <= '0;
    else                        cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/ldiag_ctrl.sv
module ldiag_ctrl
  import ldiag_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int CW         = 8,
  parameter int SYNC_LEN   = 40,
  parameter int PHASE_LEN  = 10,
  parameter int SETTLE_LEN = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_req,
  input  logic [NCH-1:0]     hiz_i,
  input  logic               seg_end,
  output ldiag_state_e       state_o,
  output logic [CW-1:0]      seg_len_o,
  output logic               start_ok_o,
  output logic               full_o,
  output logic [NCH-1:0]     mask_o,
  output logic               done_o,
  output logic               reject_o
);
  ldiag_state_e state;
  logic         idle;
  logic         start_bad;

  assign idle       = (state == ST_IDLE);
  assign start_ok_o = start_req && idle && (|hiz_i);
  assign start_bad  = start_req && idle && !(|hiz_i);
  assign state_o    = state;

  always_comb begin
    case (state)
      ST_SYNC:   seg_len_o = CW'(SYNC_LEN);
      ST_SETTLE: seg_len_o = CW'(SETTLE_LEN);
      default:   seg_len_o = CW'(PHASE_LEN);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      full_o   <= 1'b0;
      mask_o   <= '0;
      done_o   <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      reject_o <= start_bad;
      if (start_ok_o) begin
        state  <= ST_SYNC;
        full_o <= &hiz_i;
        mask_o <= hiz_i;
        done_o <= 1'b0;
      end else if (!idle && seg_end) begin
        state <= next_state(state, full_o);
        if (state == ST_SETTLE) done_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ldiag_results.sv
module ldiag_results #(
  parameter int NCH = 4,
  parameter int NPH = 4,
  localparam int IW = (NPH > 1) ? $clog2(NPH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               sample_en,
  input  logic [IW-1:0]      sample_idx,
  input  logic [NCH-1:0]     cmp_i,
  input  logic [NCH-1:0]     mask_i,
  output logic [NCH*NPH-1:0] result_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar p = 0; p < NPH; p++) begin : g_ph
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          result_o[c*NPH+p] <= 1'b0;
        else if (clear)
          result_o[c*NPH+p] <= 1'b0;
        else if (sample_en && (sample_idx == IW'(p)))
          result_o[c*NPH+p] <= cmp_i[c] & mask_i[c];
      end
    end
  end
endmodule

// File: rtl/load_diag_seq.sv
module load_diag_seq
  import ldiag_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int SYNC_CYC   = 40,
  parameter int PHASE_CYC  = 10,
  parameter int SETTLE_CYC = 30,
  parameter int CTL_W      = 8,
  parameter int START_BIT  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_wr,
  input  logic [CTL_W-1:0]     ctl_wdata,
  input  logic [NCH-1:0]       hiz_i,
  input  logic [NCH-1:0]       cmp_i,
  output logic [3:0]           phase_sel_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 reject_o,
  output logic                 full_o,
  output logic [NCH*4-1:0]     result_o
);
  localparam int MAX_A  = (SYNC_CYC > PHASE_CYC) ? SYNC_CYC : PHASE_CYC;
  localparam int MAXLEN = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
  localparam int CW     = $clog2(MAXLEN + 1);

  ldiag_state_e  state;
  logic [CW-1:0] seg_len;
  logic          seg_end;
  logic          start_req;
  logic          start_ok;
  logic [NCH-1:0] mask;
  logic          sample_en;
  logic [1:0]    sample_idx;

  assign start_req   = ctl_wr && ctl_wdata[START_BIT];
  assign busy_o      = (state != ST_IDLE);
  assign phase_sel_o = phase_onehot(state);
  assign sample_en   = is_test(state) && seg_end;
  assign sample_idx  = phase_idx(state);

  ldiag_ctrl #(
    .NCH(NCH), .CW(CW), .SYNC_LEN(SYNC_CYC),
    .PHASE_LEN(PHASE_CYC), .SETTLE_LEN(SETTLE_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .hiz_i(hiz_i),
    .seg_end(seg_end), .state_o(state), .seg_len_o(seg_len),
    .start_ok_o(start_ok), .full_o(full_o), .mask_o(mask),
    .done_o(done_o), .reject_o(reject_o)
  );

  ldiag_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy_o), .restart(start_ok),
    .len(seg_len), .seg_end(seg_end)
  );

  ldiag_results #(.NCH(NCH), .NPH(NPH)) u_res (
    .clk(clk), .rst_n(rst_n), .clear(start_ok), .sample_en(sample_en),
    .sample_idx(sample_idx), .cmp_i(cmp_i), .mask_i(mask),
    .result_o(result_o)
  );
endmodule

// File: rtl/load_diag_seq_chk.sv
module load_diag_seq_chk #(
  parameter int NCH = 4,
  parameter int NPH = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ctl_wr,
  input logic               busy_o,
  input logic               done_o,
  input logic               reject_o,
  input logic [NPH-1:0]     phase_sel_o,
  input logic [NCH*NPH-1:0] result_o,
  input logic               seg_end,
  input logic               sample_en
);
  // R5
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase_sel_o));
  // R5
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (phase_sel_o == '0));
  // R5
  seg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !seg_end);
  // R8
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o));
  // R8
  clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (result_o == '0));
  // R9
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ctl_wr) |=> !reject_o);
  // R2
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |-> !busy_o);
  // R6
  hold_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && ($past(phase_sel_o) == '0)) |-> $stable(result_o));
  // R6
  sample_in_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (phase_sel_o != '0));
endmodule

bind load_diag_seq load_diag_seq_chk #(.NCH(NCH), .NPH(NPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .busy_o(busy_o),
  .done_o(done_o), .reject_o(reject_o), .phase_sel_o(phase_sel_o),
  .result_o(result_o), .seg_end(seg_end), .sample_en(sample_en)
);

// File: tb/load_diag_seq_tb.sv
module load_diag_seq_tb;
  localparam int SYNC  = 40;
  localparam int PH    = 10;
  localparam int SET   = 30;
  localparam int FULL_LEN = SYNC + 4*PH + SET;
  localparam int RED_LEN  = SYNC + 2*PH + SET;

  // {hiz[3:0], pattern: window3, window2, window1, window0 nibbles}
  localparam logic [19:0] VECS [7] = '{
    {4'hF, 16'h8421}, {4'hF, 16'hFFFF}, {4'hF, 16'h0000},
    {4'h7, 16'hFF5A}, {4'h1, 16'hFFFF}, {4'h8, 16'h00C3},
    {4'hF, 16'h5A3C}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [3:0]  hiz = '0;
  logic [3:0]  cmp;
  logic [15:0] pat = '0;
  logic [3:0]  phase_sel;
  logic        busy, done, reject, full;
  logic [15:0] result;
  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  always_comb begin
    case (phase_sel)
      4'b0001: cmp = pat[3:0];
      4'b0010: cmp = pat[7:4];
      4'b0100: cmp = pat[11:8];
      4'b1000: cmp = pat[15:12];
      default: cmp = 4'hF;
    endcase
  end

  load_diag_seq #(.NCH(4), .SYNC_CYC(SYNC), .PHASE_CYC(PH), .SETTLE_CYC(SET)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .hiz_i(hiz), .cmp_i(cmp), .phase_sel_o(phase_sel), .busy_o(busy),
    .done_o(done), .reject_o(reject), .full_o(full), .result_o(result)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_res(logic [3:0] hz, logic [15:0] pt);
    logic [15:0] r;
    logic f;
    r = '0;
    f = &hz;
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 4; p++)
        r[4*c+p] = hz[c] && (f || p < 2) && pt[4*p+c];
    return r;
  endfunction

  task automatic write_ctl(input logic [7:0] d);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  // wr_at >= 0: extra start write with hiz cleared at that busy cycle
  task automatic run_test(input logic [3:0] hz, input logic [15:0] pt, input int wr_at);
    int n, first, plen, bad_plen;
    logic [3:0] prev;
    logic [15:0] plog;
    logic f;
    f = &hz;
    hiz = hz;
    pat = pt;
    write_ctl(8'h01);
    n = 0; first = -1; plen = 0; bad_plen = 0; prev = '0; plog = '0;
    while (busy && n < 2000) begin
      if (phase_sel != prev) begin
        if (phase_sel != '0) begin
          plog = {plog[11:0], phase_sel};
          if (first < 0) first = n;
        end
        if (prev != '0 && plen != PH) bad_plen++;
        plen = 0;
      end
      if (phase_sel != '0) plen++;
      prev = phase_sel;
      if (n == wr_at) begin
        ctl_wr = 1'b1; ctl_wdata = 8'h01; hiz = 4'h0;
      end
      if (n == wr_at + 1) begin
        ctl_wr = 1'b0; hiz = hz;
        chk("R9 no refusal while busy", {31'd0, reject}, 32'd0);
        chk("R9 still busy after write", {31'd0, busy}, 32'd1);
      end
      @(negedge clk);
      n++;
    end
    chk(f ? "R3 busy length full" : "R4 busy length reduced", n, f ? FULL_LEN : RED_LEN);
    chk(f ? "R3 strobe order" : "R4 strobe order", {16'd0, plog}, f ? 32'h1248 : 32'h0012);
    chk(f ? "R3 full flag" : "R4 full flag", {31'd0, full}, {31'd0, f});
    chk("R5 first strobe offset", first, SYNC);
    chk("R5 strobe widths", bad_plen, 0);
    chk("R6 R7 results", {16'd0, result}, {16'd0, exp_res(hz, pt)});
    chk("R8 done after run", {31'd0, done}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] last;
    repeat (3) @(negedge clk);
    chk("R1 in reset outputs", {busy, done, reject, full, phase_sel, result}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after reset outputs", {busy, done, reject, full, phase_sel, result}, 32'd0);

    for (int i = 0; i < 7; i++) begin
      run_test(VECS[i][19:16], VECS[i][15:0], -1);
      @(negedge clk);
      chk("R8 done holds while idle", {31'd0, done}, 32'd1);
    end

    // R2: refusal with no channel in high-impedance
    last = result;
    hiz = 4'h0;
    write_ctl(8'h01);
    chk("R2 reject pulse", {31'd0, reject}, 32'd1);
    chk("R2 stays idle", {31'd0, busy}, 32'd0);
    chk("R2 results kept", {16'd0, result}, {16'd0, last});
    chk("R2 done kept", {31'd0, done}, 32'd1);
    @(negedge clk);
    chk("R2 reject single cycle", {31'd0, reject}, 32'd0);

    // R9: write with start bit clear
    hiz = 4'hF;
    write_ctl(8'hFE);
    chk("R9 no start without bit0", {30'd0, busy, reject}, 32'd0);
    chk("R9 results untouched", {16'd0, result}, {16'd0, last});

    // R9: start writes during a run (sync, mid-window, settle)
    run_test(4'hF, 16'h9C63, 5);
    run_test(4'hF, 16'h36C9, SYNC + PH + 3);
    run_test(4'h3, 16'hA5A5, SYNC + 2*PH + 4);

    // R8: a new start clears done and results
    hiz = 4'hF;
    write_ctl(8'h01);
    chk("R8 done cleared on start", {31'd0, done}, 32'd0);
    chk("R8 results cleared on start", {16'd0, result}, 32'd0);
    while (busy) @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule